// File: doc/BRIEF.md
# Clock mode register and selector

This block holds the seven live bits of the clock configuration byte and decides which candidate source drives the master clock. Every candidate is modelled as a single-cycle enable pulse train in one fast reference domain. The trains are the fast RC, the slow RC, the external input and five taps of a multiplier. The block forwards the pulses of the chosen train on `clk_en_o`. A multiplier whose internal rate is sixteen times the external input produces the taps by dividing that rate down.

Software writes the configuration byte through a one-cycle write strobe. Each write stalls the forwarded enable for a fixed number of reference cycles. The crystal path and the multiplier each have their own warm-up timer, and the two timers run in parallel when both are enabled together. A request that is not usable yet is left pending and is taken up automatically once its source is ready. A request whose enables are missing raises a sticky flag and leaves the running source in place. Writing bit 7 requests a chip reset and returns the block to its power-on state.

Top module: `clkmode_sel`

## Requirements
- R1: After reset the active source is the slow RC (code 001), both enables are 0, the mode field is 00, and busy, pending, illegal and reset request are all 0.
- R2: Bit 6 of a written byte drives `pll_en_o`, bit 5 drives `osc_en_o`, and bits 4:3 appear on `osc_mode_o`, starting in the cycle after the write.
- R3: Select codes pick the source: 000 fast RC, 001 slow RC, 010 the external input, and 011/100/101/110/111 the multiplier tap at ×1/×2/×4/×8/×16. The taps pass one of every 16/8/4/2/1 multiplier ticks.
- R4: Code 010 needs bit 5 set, and codes 011 to 111 need bits 5 and 6 set. A write that breaks this sets `illegal_o`, which stays set until a reset, and the previously active source keeps running.
- R5: Every write that does not request a reset holds `busy_o` high and `clk_en_o` low for exactly STALL_CYC cycles, starting in the cycle after the write.
- R6: The crystal path becomes ready OSC_STAB_CYC cycles after its enable is written, and the multiplier PLL_STAB_CYC cycles after its own enable. A multiplier tap is usable only when both are ready. The two timers count concurrently.
- R7: A requested source that is already usable becomes active in the same cycle that the stall ends.
- R8: If the active source loses a required enable, the block falls back to the slow RC on the next cycle, or takes the requested source if that one is usable.
- R9: A write with bit 7 set pulses `rst_req_o` for one cycle and restores every register to its R1 value, including the illegal flag. A write with bit 7 clear never pulses it.
- R10: `pending_o` is high while the requested code is legal but differs from the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 8 | Configuration byte |
| rc_fast_tick_i | input | 1 | Fast RC pulse train |
| rc_slow_tick_i | input | 1 | Slow RC pulse train |
| xin_tick_i | input | 1 | External input pulse train |
| vco_tick_i | input | 1 | Multiplier internal pulse train (16× external) |
| clk_en_o | output | 1 | Forwarded master clock enable |
| active_sel_o | output | 3 | Code of the source in use |
| osc_en_o | output | 1 | Crystal path enable |
| pll_en_o | output | 1 | Multiplier enable |
| osc_mode_o | output | 2 | Crystal drive mode bits |
| busy_o | output | 1 | Switch-over stall in progress |
| pending_o | output | 1 | Legal request waiting for its source |
| illegal_o | output | 1 | Sticky illegal selection flag |
| rst_req_o | output | 1 | One-cycle chip reset request |

## Verification
Two things can land in the same cycle: the automatic switch to a source whose crystal timer has just expired, and a new configuration write. The bench times a second write so that it is captured on the very edge where the switch to the external input falls due. It then expects the switch to take effect, the new illegal request to set the sticky flag, and the stall to start, all together. After the stall it confirms that the source chosen on that edge is still the one in use.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int unsigned NUM_SRC       = 8;
    localparam int unsigned SEL_W         = $clog2(NUM_SRC);
    localparam int unsigned PLL_LOG2_MULT = 4;
    localparam int unsigned NUM_TAPS      = PLL_LOG2_MULT + 1;
    localparam int unsigned RST_BIT       = 7;

    localparam logic [SEL_W-1:0] SEL_RC_FAST = 3'd0;
    localparam logic [SEL_W-1:0] SEL_RC_SLOW = 3'd1;
    localparam logic [SEL_W-1:0] SEL_XIN     = 3'd2;
    localparam logic [SEL_W-1:0] SEL_PLL_X1  = 3'd3;

    typedef struct packed {
        logic             pll_en;
        logic             osc_en;
        logic [1:0]       osc_mode;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{pll_en: 1'b0, osc_en: 1'b0,
                                   osc_mode: 2'b00, sel: SEL_RC_SLOW};

    // Enables required by a select code
    function automatic logic sel_legal(logic [SEL_W-1:0] s, logic osc, logic pll);
        if (s == SEL_XIN)         return osc;
        else if (s >= SEL_PLL_X1) return osc && pll;
        else                      return 1'b1;
    endfunction

    // Source warmed up and ready to forward
    function automatic logic sel_usable(logic [SEL_W-1:0] s, logic osc_rdy, logic pll_rdy);
        if (s == SEL_XIN)         return osc_rdy;
        else if (s >= SEL_PLL_X1) return osc_rdy && pll_rdy;
        else                      return 1'b1;
    endfunction

endpackage

// File: rtl/clkmode_stab_timer.sv
module clkmode_stab_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic ready_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)               cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= LOAD;
        else         cnt_q <= cnt_d;
    end

    assign ready_o = en_i && (cnt_q == '0);

endmodule

// File: rtl/clkmode_pll_taps.sv
module clkmode_pll_taps #(
    parameter int unsigned LOG2_MULT = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             vco_tick_i,
    output logic [LOG2_MULT:0] tap_o
);
    logic [LOG2_MULT-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (!run_i)          phase_d = '0;
        else if (vco_tick_i) phase_d = phase_q + LOG2_MULT'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_d;
    end

    // Tap j passes one of every 2^(LOG2_MULT-j) internal ticks
    for (genvar j = 0; j <= LOG2_MULT; j++) begin : g_tap
        localparam int unsigned DIV_LOG2 = LOG2_MULT - j;
        localparam logic [LOG2_MULT-1:0] MASK = LOG2_MULT'((1 << DIV_LOG2) - 1);
        assign tap_o[j] = run_i && vco_tick_i && ((phase_q & MASK) == MASK);
    end

endmodule

// File: rtl/clkmode_src_mux.sv
module clkmode_src_mux #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               hold_i,
    output logic               tick_o
);
    always_comb begin
        tick_o = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel_i == SEL_W'(k)) tick_o = tick_i[k];
        end
        if (hold_i) tick_o = 1'b0;
    end

endmodule

// File: rtl/clkmode_sel.sv
module clkmode_sel
    import clkmode_pkg::*;
#(
    parameter int unsigned STALL_CYC    = 15000,
    parameter int unsigned PLL_STAB_CYC = 20000,
    parameter int unsigned OSC_STAB_CYC = 2000000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rc_fast_tick_i,
    input  logic       rc_slow_tick_i,
    input  logic       xin_tick_i,
    input  logic       vco_tick_i,
    output logic       clk_en_o,
    output logic [2:0] active_sel_o,
    output logic       osc_en_o,
    output logic       pll_en_o,
    output logic [1:0] osc_mode_o,
    output logic       busy_o,
    output logic       pending_o,
    output logic       illegal_o,
    output logic       rst_req_o
);
    localparam int unsigned STALL_W = $clog2(STALL_CYC + 1);

    typedef struct packed {
        cfg_t               cfg;
        logic [SEL_W-1:0]   act;
        logic [STALL_W-1:0] stall;
        logic               illegal;
        logic               rst_req;
    } state_t;

    localparam state_t ST_RESET = '{cfg: CFG_RESET, act: SEL_RC_SLOW,
                                    stall: '0, illegal: 1'b0, rst_req: 1'b0};

    state_t d, q;
    cfg_t   wr_cfg;
    logic   osc_rdy, pll_rdy;
    logic   [NUM_TAPS-1:0] taps;
    logic   [NUM_SRC-1:0]  ticks;

    assign wr_cfg = cfg_t'(wr_data_i[6:0]);

    clkmode_stab_timer #(.CYCLES(OSC_STAB_CYC)) u_osc_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (q.cfg.osc_en),
        .ready_o (osc_rdy)
    );

    clkmode_stab_timer #(.CYCLES(PLL_STAB_CYC)) u_pll_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (q.cfg.pll_en),
        .ready_o (pll_rdy)
    );

    clkmode_pll_taps #(.LOG2_MULT(PLL_LOG2_MULT)) u_taps (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (q.cfg.pll_en && q.cfg.osc_en),
        .vco_tick_i (vco_tick_i),
        .tap_o      (taps)
    );

    assign ticks = {taps, xin_tick_i && q.cfg.osc_en, rc_slow_tick_i, rc_fast_tick_i};

    clkmode_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .tick_i (ticks),
        .sel_i  (q.act),
        .hold_i (q.stall != '0),
        .tick_o (clk_en_o)
    );

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;

        if (q.stall != '0) d.stall = q.stall - STALL_W'(1);

        // Take the request once the stall is ending and the source is ready;
        // otherwise leave a source that has lost its enables
        if (q.stall <= STALL_W'(1) && sel_usable(q.cfg.sel, osc_rdy, pll_rdy)) begin
            d.act = q.cfg.sel;
        end else if (!sel_usable(q.act, osc_rdy, pll_rdy)) begin
            d.act = SEL_RC_SLOW;
        end

        if (wr_en_i) begin
            if (wr_data_i[RST_BIT]) begin
                d         = ST_RESET;
                d.rst_req = 1'b1;
            end else begin
                d.cfg   = wr_cfg;
                d.stall = STALL_W'(STALL_CYC);
                if (!sel_legal(wr_cfg.sel, wr_cfg.osc_en, wr_cfg.pll_en)) begin
                    d.illegal = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= ST_RESET;
        else         q <= d;
    end

    assign active_sel_o = q.act;
    assign osc_en_o     = q.cfg.osc_en;
    assign pll_en_o     = q.cfg.pll_en;
    assign osc_mode_o   = q.cfg.osc_mode;
    assign busy_o       = (q.stall != '0);
    assign pending_o    = sel_legal(q.cfg.sel, q.cfg.osc_en, q.cfg.pll_en)
                          && (q.cfg.sel != q.act);
    assign illegal_o    = q.illegal;
    assign rst_req_o    = q.rst_req;

endmodule

// File: rtl/clkmode_sel_chk.sv
module clkmode_sel_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       clk_en_o,
    input logic [2:0] active_sel_o,
    input logic       osc_en_o,
    input logic       busy_o,
    input logic       illegal_o,
    input logic       rst_req_o
);
    // R5
    stall_gates_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !clk_en_o);

    // R5
    write_starts_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[7]) |=> busy_o);

    // R9
    reset_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[7]) |=> (rst_req_o && active_sel_o == 3'd1 && !osc_en_o));

    // R9
    reset_req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R4
    illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(illegal_o) |-> rst_req_o);

    // R8
    lost_source_leaves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_sel_o == 3'd2 && !osc_en_o) |=> (active_sel_o != 3'd2));

endmodule

bind clkmode_sel clkmode_sel_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .clk_en_o     (clk_en_o),
    .active_sel_o (active_sel_o),
    .osc_en_o     (osc_en_o),
    .busy_o       (busy_o),
    .illegal_o    (illegal_o),
    .rst_req_o    (rst_req_o)
);

// File: tb/clkmode_sel_tb.sv
module clkmode_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STALL      = 4;
    localparam int PLL_STAB   = 10;
    localparam int OSC_STAB   = 40;
    localparam int WINDOW     = 96;
    localparam int NVEC       = 11;

    // {write byte, expected active code, expected illegal, expected pulses per WINDOW}
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {8'h00, 3'd0, 1'b0, 8'd32},
        {8'h01, 3'd1, 1'b0, 8'd3},
        {8'h22, 3'd2, 1'b0, 8'd16},
        {8'h63, 3'd3, 1'b0, 8'd6},
        {8'h64, 3'd4, 1'b0, 8'd12},
        {8'h65, 3'd5, 1'b0, 8'd24},
        {8'h66, 3'd6, 1'b0, 8'd48},
        {8'h7F, 3'd7, 1'b0, 8'd96},
        {8'h02, 3'd1, 1'b1, 8'd3},
        {8'h27, 3'd1, 1'b1, 8'd3},
        {8'h47, 3'd1, 1'b1, 8'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rc_fast = 1'b0, rc_slow = 1'b0, xin = 1'b0;
    logic       vco = 1'b1;
    logic       clk_en, osc_en, pll_en, busy, pending, illegal, rst_req;
    logic [2:0] act;
    logic [1:0] mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkmode_sel #(
        .STALL_CYC    (STALL),
        .PLL_STAB_CYC (PLL_STAB),
        .OSC_STAB_CYC (OSC_STAB)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .wr_en_i        (wr_en),
        .wr_data_i      (wr_data),
        .rc_fast_tick_i (rc_fast),
        .rc_slow_tick_i (rc_slow),
        .xin_tick_i     (xin),
        .vco_tick_i     (vco),
        .clk_en_o       (clk_en),
        .active_sel_o   (act),
        .osc_en_o       (osc_en),
        .pll_en_o       (pll_en),
        .osc_mode_o     (mode),
        .busy_o         (busy),
        .pending_o      (pending),
        .illegal_o      (illegal),
        .rst_req_o      (rst_req)
    );

    // Periodic source trains: fast RC every 3rd, slow RC every 32nd, external every 6th
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            #1;
            n++;
            rc_fast = (n % 3 == 0);
            rc_slow = (n % 32 == 0);
            xin     = (n % 6 == 0);
        end
    end

    task automatic check(string req, string what, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Byte is captured on the second rising edge after the call
    task automatic wr(logic [7:0] b);
        @(posedge clk);
        #1;
        wr_en   = 1'b1;
        wr_data = b;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic count_pulses(output int cnt);
        cnt = 0;
        for (int i = 0; i < WINDOW; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int cnt;

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", "active", act, 1);
        check("R1", "osc_en", osc_en, 0);
        check("R1", "pll_en", pll_en, 0);
        check("R1", "mode", mode, 0);
        check("R1", "busy", busy, 0);
        check("R1", "pending", pending, 0);
        check("R1", "illegal", illegal, 0);
        check("R1", "rst_req", rst_req, 0);

        // R3 / R4: table walk, each vector from a fresh reset
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] b;
            logic [2:0] ea;
            logic       ei;
            logic [7:0] ec;
            string      tag;
            {b, ea, ei, ec} = VEC[v];
            tag = ei ? "R4" : "R3";
            do_reset();
            wr(b);
            repeat (60) @(posedge clk);
            @(negedge clk);
            check(tag, $sformatf("vec%0d active", v), act, ea);
            check(tag, $sformatf("vec%0d illegal", v), illegal, ei);
            count_pulses(cnt);
            check(tag, $sformatf("vec%0d pulses", v), cnt, ec);
        end

        // R2: field positions
        do_reset();
        wr(8'h7F);
        @(negedge clk);
        check("R2", "pll_en", pll_en, 1);
        check("R2", "osc_en", osc_en, 1);
        check("R2", "mode", mode, 3);
        wr(8'h28);
        @(negedge clk);
        check("R2", "pll_en off", pll_en, 0);
        check("R2", "osc_en on", osc_en, 1);
        check("R2", "mode 01", mode, 1);

        // R5 / R7: stall length and switch at stall end
        do_reset();
        wr(8'h00);
        for (int k = 0; k < STALL; k++) begin
            @(negedge clk);
            check("R5", $sformatf("busy c%0d", k), busy, 1);
            check("R5", $sformatf("clk_en c%0d", k), clk_en, 0);
        end
        @(negedge clk);
        check("R5", "busy after stall", busy, 0);
        check("R7", "fast active at stall end", act, 0);

        // R6 / R10: overlapping warm-up, pending, auto switch
        do_reset();
        wr(8'h63);
        repeat (OSC_STAB) @(posedge clk);
        @(negedge clk);
        check("R6", "still slow before crystal ready", act, 1);
        check("R10", "pending while warming", pending, 1);
        @(negedge clk);
        check("R6", "x1 tap active once both ready", act, 3);
        check("R10", "pending cleared", pending, 0);

        // R7: free switching once stable
        wr(8'h67);
        repeat (STALL - 1) @(posedge clk);
        @(negedge clk);
        check("R7", "old tap during stall", act, 3);
        @(negedge clk);
        check("R7", "x16 tap at stall end", act, 7);
        check("R7", "busy low", busy, 0);

        // R8: active source loses its enable
        do_reset();
        wr(8'h22);
        repeat (45) @(posedge clk);
        @(negedge clk);
        check("R8", "external active", act, 2);
        wr(8'h02);
        @(posedge clk);
        @(negedge clk);
        check("R8", "fallback to slow", act, 1);
        check("R4", "illegal set", illegal, 1);

        // R4 / R6: write lands on the edge where the crystal switch falls due
        do_reset();
        wr(8'h22);
        repeat (OSC_STAB - 1) @(posedge clk);
        wr(8'h26);
        @(negedge clk);
        check("R6", "switch taken with write", act, 2);
        check("R4", "illegal from same-edge write", illegal, 1);
        check("R5", "stall from same-edge write", busy, 1);
        repeat (STALL + 1) @(posedge clk);
        @(negedge clk);
        check("R4", "valid source kept", act, 2);
        check("R4", "illegal still set", illegal, 1);

        // R9: reset request
        wr(8'h80);
        @(negedge clk);
        check("R9", "rst_req pulse", rst_req, 1);
        check("R9", "illegal cleared", illegal, 0);
        check("R9", "active back to slow", act, 1);
        check("R9", "osc_en cleared", osc_en, 0);
        @(negedge clk);
        check("R9", "rst_req one cycle", rst_req, 0);
        wr(8'h01);
        @(negedge clk);
        check("R9", "bit7 clear gives no pulse", rst_req, 0);
        check("R9", "slow still active", act, 1);

        report();
    end

endmodule